// File: doc/BRIEF.md
# Vector Permute Alignment Unit

This block realigns vector data that sits across two aligned 128-bit blocks. It has two jobs. The first is to build a 16-byte shift control vector, for a left or a right shift, from a base operand and an index operand. The second is to use any such control vector to pick bytes out of two 128-bit source vectors. Software pairs the two jobs: it asks for a mask for a given misalignment, then sends that mask back as the control of a permute over the two aligned blocks, which yields the shifted vector.

The shift amount `sh` is the low four bits of the effective address, where the effective address is the base plus the index. When `base_zero_i` is set, a literal zero replaces the base. Nothing is read from memory. All vectors number their bytes big-endian: byte 0 is bits 127:120.

Every request is registered. `result_o` and `valid_o` change one clock after a cycle in which `req_i` is high. A two-state controller tracks the strobe:
- ST_IDLE goes to ST_EMIT on a request (ACCEPT), or stays in ST_IDLE (WAIT).
- ST_EMIT stays in ST_EMIT on a further request (CHAIN), or goes back to ST_IDLE (RETIRE).

`valid_o` is high exactly while the controller is in ST_EMIT. Neither mode produces flags or exceptions.

Top module: `vec_align_unit`

## Requirements
- R1: The effective address is (`base_zero_i` ? 0 : `base_i`) + `index_i`, wrapping modulo 2^64. Only its low four bits, `sh`, affect the result.
- R2: With `mode_i` = 2'b00 (left mask), result byte i is sh + i, for i = 0..15.
- R3: With `mode_i` = 2'b01 (right mask), result byte i is 16 − sh + i. So sh = 0 gives bytes 16..31, and sh = 3 gives bytes 13..28.
- R4: Byte 0 of every vector, ports included, occupies bits 127:120, and byte i occupies bits 127−8i down to 120−8i.
- R5: With `mode_i` = 2'b10 (permute), the low five bits of control byte i choose result byte i. If bit 4 is set, the result takes a byte of `src_b_i`; if bit 4 is clear, it takes a byte of `src_a_i`. Bits 3:0 give the byte number within the chosen vector.
- R6: Bits 7:5 of every control byte have no effect on the permute result.
- R7: `valid_o` is high in exactly those cycles that follow a cycle with `req_i` high. That same clock loads `result_o` with the result of the request.
- R8: After a cycle with `req_i` low, `result_o` is unchanged, whatever the other inputs do.
- R9: A synchronous reset `rst` clears `valid_o` and `result_o` to zero.
- R10: With `mode_i` = 2'b11, the registered result is all zero and `valid_o` still rises.
- R11: A permute driven by the left mask for sh returns bytes sh..sh+15 of the 32-byte concatenation {src_a, src_b}. A permute driven by the right mask for sh returns bytes 16−sh..31−sh of that concatenation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe |
| mode_i | input | 2 | 00 left mask, 01 right mask, 10 permute, 11 zero |
| base_i | input | 64 | Base operand |
| base_zero_i | input | 1 | Replace the base with zero |
| index_i | input | 64 | Index operand |
| src_a_i | input | 128 | First permute source |
| src_b_i | input | 128 | Second permute source |
| ctrl_i | input | 128 | Permute control vector |
| valid_o | output | 1 | Result valid, one cycle after a request |
| result_o | output | 128 | Registered result |

## Verification
The assertions watch, on every cycle:
- the request-to-valid timing and the holding of the result between requests;
- the reset state;
- the zero result of the spare mode;
- byte 0 of a left mask against the low nibble of the effective address;
- the fixed span of 15 between the first and last mask bytes;
- the source choice for lane 0 in permute mode.

Only the bench's sweeps can show the rest:
- the full byte pattern of both masks over all sixteen shift amounts;
- carry wrap-around in the address sum;
- per-lane selection over varied control vectors, including set upper bits;
- that each mask, fed back as a permute control, reproduces a byte shift of the two sources.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

    typedef enum logic [1:0] {
        MODE_SHL  = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_PERM = 2'b10,
        MODE_RSVD = 2'b11
    } vpa_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vpa_state_e;

endpackage

// File: rtl/vpa_mask_gen.sv
module vpa_mask_gen #(
    parameter int BYTES  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]       base_i,
    input  logic                    base_zero_i,
    input  logic [ADDR_W-1:0]       index_i,
    input  logic                    right_i,
    output logic [BYTES*BYTE_W-1:0] mask_o
);
    localparam int SH_W = $clog2(BYTES);

    logic [ADDR_W-1:0] eff_addr;
    logic [SH_W-1:0]   sh;
    logic              unused_addr_hi;

    // Full-width sum wraps naturally; only the low nibble is consumed.
    assign eff_addr       = (base_zero_i ? '0 : base_i) + index_i;
    assign sh             = eff_addr[SH_W-1:0];
    assign unused_addr_hi = ^eff_addr[ADDR_W-1:SH_W];

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] left_val;
        logic [BYTE_W-1:0] right_val;
        assign left_val  = BYTE_W'(sh) + BYTE_W'(i);
        assign right_val = BYTE_W'(BYTES) - BYTE_W'(sh) + BYTE_W'(i);
        assign mask_o[(BYTES-1-i)*BYTE_W +: BYTE_W] = right_i ? right_val : left_val;
    end

endmodule

// File: rtl/vpa_byte_select.sv
module vpa_byte_select #(
    parameter int BYTES  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [BYTES*BYTE_W-1:0] src_a_i,
    input  logic [BYTES*BYTE_W-1:0] src_b_i,
    input  logic [BYTES*BYTE_W-1:0] ctrl_i,
    output logic [BYTES*BYTE_W-1:0] result_o
);
    localparam int SEL_W = $clog2(BYTES) + 1;
    localparam int PAD_W = BYTE_W - SEL_W;
    localparam int CAT_B = 2 * BYTES;

    logic [CAT_B*BYTE_W-1:0] pool;
    logic [BYTES-1:0]        unused_ctrl_hi;

    // Byte 0 of the pool is the top byte of the first source.
    assign pool = {src_a_i, src_b_i};

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        logic [SEL_W-1:0] sel;
        assign sel = ctrl_i[(BYTES-1-i)*BYTE_W +: SEL_W];
        assign unused_ctrl_hi[i] = ^ctrl_i[(BYTES-1-i)*BYTE_W + SEL_W +: PAD_W];
        assign result_o[(BYTES-1-i)*BYTE_W +: BYTE_W] =
            pool[(CAT_B-1-int'(sel))*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/vpa_ctrl.sv
module vpa_ctrl
    import vpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic valid_o
);
    vpa_state_e state_q;
    vpa_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ACCEPT / WAIT from idle, CHAIN / RETIRE from emit.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        valid_o = (state_q == ST_EMIT);
    end

endmodule

// File: rtl/vec_align_unit.sv
module vec_align_unit
    import vpa_pkg::*;
#(
    parameter int BYTES  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_i,
    input  logic [1:0]              mode_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic                    base_zero_i,
    input  logic [ADDR_W-1:0]       index_i,
    input  logic [BYTES*BYTE_W-1:0] src_a_i,
    input  logic [BYTES*BYTE_W-1:0] src_b_i,
    input  logic [BYTES*BYTE_W-1:0] ctrl_i,
    output logic                    valid_o,
    output logic [BYTES*BYTE_W-1:0] result_o
);
    localparam int VEC_W = BYTES * BYTE_W;

    vpa_mode_e  mode;
    logic [VEC_W-1:0] mask_vec;
    logic [VEC_W-1:0] perm_vec;

    assign mode = vpa_mode_e'(mode_i);

    vpa_mask_gen #(.BYTES(BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_mask (
        .base_i      (base_i),
        .base_zero_i (base_zero_i),
        .index_i     (index_i),
        .right_i     (mode == MODE_SHR),
        .mask_o      (mask_vec)
    );

    vpa_byte_select #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_sel (
        .src_a_i  (src_a_i),
        .src_b_i  (src_b_i),
        .ctrl_i   (ctrl_i),
        .result_o (perm_vec)
    );

    vpa_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .valid_o (valid_o)
    );

    // Result register, loaded only on a request.
    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
        end else if (req_i) begin
            unique case (mode)
                MODE_SHL, MODE_SHR: result_o <= mask_vec;
                MODE_PERM:          result_o <= perm_vec;
                MODE_RSVD:          result_o <= '0;
                default:            result_o <= '0;
            endcase
        end
    end

endmodule

// File: rtl/vpa_align_chk.sv
module vpa_align_chk (
    input logic         clk,
    input logic         rst,
    input logic         req_i,
    input logic [1:0]   mode_i,
    input logic [3:0]   base_lo,
    input logic         base_zero_i,
    input logic [3:0]   index_lo,
    input logic [7:0]   src_a_b0,
    input logic [7:0]   src_b_b0,
    input logic [4:0]   ctrl_b0,
    input logic         valid_o,
    input logic [127:0] result_o
);
    logic [3:0] ea_nib;
    assign ea_nib = (base_zero_i ? 4'd0 : base_lo) + index_lo;

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o);

    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !valid_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> $stable(result_o));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!valid_o && result_o == '0));

    assert_left_first_R2: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b00) |=> result_o[127:120] == {4'd0, $past(ea_nib)});

    assert_mask_span_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i && !mode_i[1]) |=> (result_o[7:0] - result_o[127:120]) == 8'd15);

    assert_spare_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b11) |=> result_o == '0);

    assert_perm_from_a_R5: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b10 && ctrl_b0 == 5'd0) |=> result_o[127:120] == $past(src_a_b0));

    assert_perm_from_b_R5: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b10 && ctrl_b0 == 5'd16) |=> result_o[127:120] == $past(src_b_b0));

endmodule

bind vec_align_unit vpa_align_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .mode_i      (mode_i),
    .base_lo     (base_i[3:0]),
    .base_zero_i (base_zero_i),
    .index_lo    (index_i[3:0]),
    .src_a_b0    (src_a_i[127:120]),
    .src_b_b0    (src_b_i[127:120]),
    .ctrl_b0     (ctrl_i[124:120]),
    .valid_o     (valid_o),
    .result_o    (result_o)
);

// File: tb/vec_align_unit_tb.sv
module vec_align_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_i = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic [63:0]  base_i = '0;
    logic         base_zero_i = 1'b0;
    logic [63:0]  index_i = '0;
    logic [127:0] src_a_i = '0;
    logic [127:0] src_b_i = '0;
    logic [127:0] ctrl_i = '0;
    logic         valid_o;
    logic [127:0] result_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

    vec_align_unit u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i),
        .base_i(base_i), .base_zero_i(base_zero_i), .index_i(index_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .ctrl_i(ctrl_i),
        .valid_o(valid_o), .result_o(result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic rnd(output logic [63:0] v);
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        v = seed ^ (seed >> 29);
    endtask

    task automatic rnd128(output logic [127:0] v);
        logic [63:0] h, l;
        rnd(h);
        rnd(l);
        v = {h, l};
    endtask

    function automatic logic [7:0] vbyte(logic [127:0] v, int k);
        return v[127-8*k -: 8];
    endfunction

    function automatic logic [127:0] exp_mask(logic right, int sh);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[127-8*i -: 8] = right ? 8'(16 - sh + i) : 8'(sh + i);
        return r;
    endfunction

    function automatic logic [127:0] exp_perm(logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] r;
        logic [7:0] s;
        for (int i = 0; i < 16; i++) begin
            s = vbyte(c, i);
            r[127-8*i -: 8] = s[4] ? vbyte(b, int'(s[3:0])) : vbyte(a, int'(s[3:0]));
        end
        return r;
    endfunction

    function automatic logic [127:0] exp_shift(logic [127:0] a, logic [127:0] b, int off);
        logic [127:0] r;
        for (int i = 0; i < 16; i++)
            r[127-8*i -: 8] = (off + i < 16) ? vbyte(a, off + i) : vbyte(b, off + i - 16);
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] m, logic [63:0] b, logic bz, logic [63:0] ix,
                          logic [127:0] a, logic [127:0] bb, logic [127:0] c);
        @(negedge clk);
        req_i = 1'b1; mode_i = m; base_i = b; base_zero_i = bz; index_i = ix;
        src_a_i = a; src_b_i = bb; ctrl_i = c;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0]  b, x;
        logic [127:0] a, bb, c, held, msk;
        logic         r9_ok;
        int           sh;

        repeat (3) @(negedge clk);
        r9_ok = (valid_o === 1'b0);
        check("R9 valid in reset", {127'd0, !r9_ok}, '0);
        check("R9 result in reset", result_o, '0);
        rst = 1'b0;

        // R1 R2 R3 R7: all shift amounts, both mask modes, with carry wrap
        for (int right = 0; right < 2; right++) begin
            for (int s = 0; s < 16; s++) begin
                rnd(b);
                rnd(x);
                b = b | 64'hFFFF_FFFF_FFFF_FF00;
                x[3:0] = 4'(s) - b[3:0];
                x = x | 64'hF000_0000_0000_0000;
                run_op(right[0] ? 2'b01 : 2'b00, b, 1'b0, x, '0, '0, '0);
                check(right ? "R3 right mask sweep R1" : "R2 left mask sweep R1",
                      result_o, exp_mask(right[0], s));
                check("R7 valid after request", {127'd0, valid_o}, 128'd1);
            end
        end

        // R1: base forced to zero
        run_op(2'b00, 64'hFFFF_FFFF_FFFF_FFFB, 1'b1, 64'h0000_0000_0000_1235, '0, '0, '0);
        check("R1 base zero flag", result_o, exp_mask(1'b0, 5));

        // R3 literal corner values, R4 byte placement
        run_op(2'b01, 64'd0, 1'b1, 64'h40, '0, '0, '0);
        check("R3 sh0 right", result_o, 128'h101112131415161718191A1B1C1D1E1F);
        run_op(2'b01, 64'd1, 1'b0, 64'd2, '0, '0, '0);
        check("R3 sh3 right", result_o, 128'h0D0E0F101112131415161718191A1B1C);
        run_op(2'b00, 64'd16, 1'b0, 64'd32, '0, '0, '0);
        check("R4 byte0 top bits", {120'd0, result_o[127:120]}, 128'd0);
        check("R4 byte15 low bits", {120'd0, result_o[7:0]}, 128'd15);

        // R5 R6: permute patterns, then with upper selector bits set
        for (int t = 0; t < 40; t++) begin
            rnd128(a);
            rnd128(bb);
            rnd128(c);
            c = c & {16{8'h1F}};
            run_op(2'b10, '0, 1'b0, '0, a, bb, c);
            check("R5 permute", result_o, exp_perm(a, bb, c));
            run_op(2'b10, '0, 1'b0, '0, a, bb, c | {16{8'hE0}});
            check("R6 upper selector bits ignored", result_o, exp_perm(a, bb, c));
        end

        // R11: mask fed back as permute control reproduces a byte shift
        for (int right = 0; right < 2; right++) begin
            for (int s = 0; s < 16; s++) begin
                rnd128(a);
                rnd128(bb);
                run_op(right[0] ? 2'b01 : 2'b00, 64'd0, 1'b1, 64'(s), '0, '0, '0);
                msk = result_o;
                run_op(2'b10, '0, 1'b0, '0, a, bb, msk);
                sh = right ? 16 - s : s;
                check("R11 shift by mask", result_o, exp_shift(a, bb, sh));
            end
        end

        // R10: spare mode gives zero and still valid
        run_op(2'b10, '0, 1'b0, '0, {16{8'hAA}}, {16{8'h55}}, '0);
        run_op(2'b11, 64'h5, 1'b0, 64'h7, {16{8'hAA}}, {16{8'h55}}, '0);
        check("R10 spare mode zero", result_o, '0);
        check("R10 spare mode valid", {127'd0, valid_o}, 128'd1);

        // R8: idle cycle with changed inputs keeps the result
        run_op(2'b00, 64'd0, 1'b1, 64'd9, '0, '0, '0);
        held = result_o;
        mode_i = 2'b01; index_i = 64'd2; ctrl_i = {16{8'h13}};
        @(negedge clk);
        check("R8 result held", result_o, held);
        check("R7 valid low when idle", {127'd0, valid_o}, 128'd0);

        // R7: back-to-back requests
        @(negedge clk);
        req_i = 1'b1; mode_i = 2'b00; base_zero_i = 1'b1; index_i = 64'd4;
        @(negedge clk);
        check("R7 first of pair", result_o, exp_mask(1'b0, 4));
        check("R7 valid first of pair", {127'd0, valid_o}, 128'd1);
        mode_i = 2'b01; index_i = 64'd6;
        @(negedge clk);
        req_i = 1'b0;
        check("R7 second of pair", result_o, exp_mask(1'b1, 6));
        check("R7 valid second of pair", {127'd0, valid_o}, 128'd1);
        @(negedge clk);
        check("R7 valid retires", {127'd0, valid_o}, 128'd0);

        // R9: reset in mid-run clears state
        @(negedge clk);
        rst = 1'b1; req_i = 1'b1;
        @(negedge clk);
        rst = 1'b0; req_i = 1'b0;
        check("R9 reset clears result", result_o, '0);
        check("R9 reset clears valid", {127'd0, valid_o}, 128'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule